// File: doc/BRIEF.md
# Decimating Pretrigger Capture Engine

This block is the storage half of a logic-analyzer style scope. It takes a narrow sample word whenever its sample-enable strobe is high, optionally keeps only one of every 2^N enabled samples, packs the kept samples into bytes, and writes those bytes into a circular on-chip buffer. A trigger pulse from outside ends the history phase. The engine holds a programmable share of the buffer as pre-trigger history, fills the remainder after the trigger, and then stops.

Once stopped, a host pulls the buffer back one byte per next-word request. It starts from the oldest byte and walks the buffer circularly. A 2-bit status code reports the phase. Capture begins with a start pulse, which gives free-running capture, or with a rearm pulse, which arms the trigger.

Top module: `cap_engine`

## Requirements
- R1: After the asynchronous active-high reset, status is 00 (stopped), rd_valid is 0 and rd_data is 0.
- R2: A start pulse while status is 00 (and no rearm in that cycle) moves status to 01 (free-running capture) on the next edge. A start pulse in any other status has no effect.
- R3: With decimation control N, exactly one of every 2^N samples is kept, counting only cycles in which smp_en is 1 and capture is active.
- R4: Kept samples of width SAMPLE_W are packed into a byte with the first sample in bits [SAMPLE_W-1:0] and later samples in higher bits. A byte is stored after 8/SAMPLE_W kept samples.
- R5: A rearm pulse moves status to 10 (armed) on the next edge from any status. When it is given in status 00, the stored history count and the write position restart from zero.
- R6: The pre-trigger depth is floor(DEPTH*p/100), with p chosen by pos_code: 00 gives 0, 01 gives 10, 10 gives 50, 11 gives 90. A trigger in status 10 while at least that many bytes have been stored since capture began moves status to 11 on the next edge.
- R7: A trigger that arrives in status 10 before enough history exists is remembered. Status becomes 11 on the edge after the stored byte count first reaches the pre-trigger depth.
- R8: After the trigger is taken, exactly DEPTH minus the pre-trigger depth further bytes are stored, and the edge storing the last one sets status to 00. While stopped, samples are ignored.
- R9: Trigger pulses have no effect in status 01, 11 or 00.
- R10: A next_req pulse in status 00 (without start or rearm) gives rd_valid=1 on the following cycle, with rd_data holding the next byte. The first byte read after a capture is the oldest stored one, and reads wrap circularly through all DEPTH bytes.
- R11: next_req pulses in any status other than 00 produce no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| decim_n | input | DEC_W | Decimation exponent N |
| pos_code | input | 2 | Pre-trigger share selector |
| smp_in | input | SAMPLE_W | Sample word |
| smp_en | input | 1 | Sample-enable strobe |
| trig | input | 1 | One-cycle trigger pulse |
| rearm | input | 1 | One-cycle rearm pulse |
| start | input | 1 | One-cycle free-run start pulse |
| next_req | input | 1 | One-cycle request for the next readback byte |
| rd_data | output | 8 | Readback byte |
| rd_valid | output | 1 | rd_data valid strobe |
| status | output | 2 | 00 stopped, 01 free-running, 10 armed, 11 post-trigger |

## Verification
The collision of interest is a trigger being evaluated in the same cycle as the byte write that completes the required history. The history count used for the decision is the value before that write, so a trigger at history depth minus one is held and then taken one edge later. The bench provokes this by pulsing the trigger with no history at all and then feeding exactly the number of samples that fill the pre-trigger depth. It then expects status 11 exactly one edge after the last needed byte. A second collision, rearm and start together while stopped, is resolved in favour of rearm. The behavioural model in the bench applies the same rules independently and is compared with the block on every clock.

// File: rtl/cap_pkg.sv
package cap_pkg;

   typedef enum logic [1:0] {
      ST_STOPPED = 2'b00,
      ST_FREE    = 2'b01,
      ST_ARMED   = 2'b10,
      ST_POST    = 2'b11
   } cap_state_e;

   // Number of history bytes kept ahead of the trigger point.
   function automatic int unsigned pre_depth(input logic [1:0] code, input int unsigned depth);
      case (code)
         2'b00:   return 0;
         2'b01:   return (depth * 10) / 100;
         2'b10:   return (depth * 50) / 100;
         default: return (depth * 90) / 100;
      endcase
   endfunction

endpackage

// File: rtl/cap_decim.sv
module cap_decim #(
   parameter int DEC_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             en,
   input  logic [DEC_W-1:0] n,
   output logic             keep
);
   localparam int CW = (1 << DEC_W) - 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] mask;

   assign mask = ~({CW{1'b1}} << n);
   assign keep = en && (cnt == mask);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (en)   cnt <= keep ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/cap_pack.sv
module cap_pack #(
   parameter int SAMPLE_W = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                clr,
   input  logic                keep,
   input  logic [SAMPLE_W-1:0] smp,
   output logic                byte_vld,
   output logic [7:0]          byte_out
);
   generate
      if (SAMPLE_W == 8) begin : g_wide
         logic unused_sink;
         assign unused_sink = &{1'b0, clk, rst, clr};
         assign byte_vld    = keep;
         assign byte_out    = smp;
      end else begin : g_narrow
         localparam int PER = 8 / SAMPLE_W;
         localparam int IW  = $clog2(PER);

         logic [IW-1:0] idx;
         logic [7:0]    acc;
         logic [7:0]    merged;

         always_comb begin
            merged = acc;
            merged[idx*SAMPLE_W +: SAMPLE_W] = smp;
         end

         assign byte_vld = keep && (idx == IW'(PER - 1));
         assign byte_out = merged;

         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               acc <= '0;
               idx <= '0;
            end else if (clr) begin
               acc <= '0;
               idx <= '0;
            end else if (keep) begin
               acc <= merged;
               idx <= byte_vld ? '0 : idx + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cap_store.sv
module cap_store #(
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic          rd_valid
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= mem[rd_addr];
      end
   end
endmodule

// File: rtl/cap_engine.sv
module cap_engine
   import cap_pkg::*;
#(
   parameter int SAMPLE_W = 2,
   parameter int DEPTH    = 32,
   parameter int DEC_W    = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [DEC_W-1:0]    decim_n,
   input  logic [1:0]          pos_code,
   input  logic [SAMPLE_W-1:0] smp_in,
   input  logic                smp_en,
   input  logic                trig,
   input  logic                rearm,
   input  logic                start,
   input  logic                next_req,
   output logic [7:0]          rd_data,
   output logic                rd_valid,
   output logic [1:0]          status
);
   localparam int AW    = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (!(SAMPLE_W == 1 || SAMPLE_W == 2 || SAMPLE_W == 4 || SAMPLE_W == 8)) begin : g_bad_width
         $error("cap_engine: SAMPLE_W must be 1, 2, 4 or 8");
      end
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("cap_engine: DEPTH must be a power of two of at least 8");
      end
      if (DEC_W < 1 || DEC_W > 8) begin : g_bad_dec
         $error("cap_engine: DEC_W must lie between 1 and 8");
      end
   endgenerate

   cap_state_e       st;
   logic             pend;
   logic [CNT_W-1:0] hist;
   logic [CNT_W-1:0] post;
   logic [AW-1:0]    wptr;
   logic [AW-1:0]    rptr;

   logic             active, restart, keep, wr, accept, rd_go;
   logic [7:0]       wr_byte;
   logic [CNT_W-1:0] pre_w;

   assign active  = (st != ST_STOPPED);
   assign restart = (st == ST_STOPPED) && (start || rearm);
   assign pre_w   = CNT_W'(pre_depth(pos_code, DEPTH));
   assign accept  = (st == ST_ARMED) && !rearm && (trig || pend) && (hist >= pre_w);
   assign rd_go   = (st == ST_STOPPED) && next_req && !start && !rearm;
   assign status  = st;

   cap_decim #(.DEC_W(DEC_W)) u_decim (
      .clk  (clk),
      .rst  (rst),
      .clr  (restart),
      .en   (smp_en && active),
      .n    (decim_n),
      .keep (keep)
   );

   cap_pack #(.SAMPLE_W(SAMPLE_W)) u_pack (
      .clk      (clk),
      .rst      (rst),
      .clr      (restart),
      .keep     (keep),
      .smp      (smp_in),
      .byte_vld (wr),
      .byte_out (wr_byte)
   );

   cap_store #(.DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr),
      .wr_addr  (wptr),
      .wr_data  (wr_byte),
      .rd_en    (rd_go),
      .rd_addr  (rptr),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st   <= ST_STOPPED;
         pend <= 1'b0;
         hist <= '0;
         post <= '0;
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (restart) begin
            hist <= '0;
            wptr <= '0;
         end else if (wr) begin
            wptr <= wptr + 1'b1;
            if (hist != CNT_W'(DEPTH)) hist <= hist + 1'b1;
         end

         if (rearm) begin
            st   <= ST_ARMED;
            pend <= 1'b0;
         end else if (st == ST_STOPPED && start) begin
            st <= ST_FREE;
         end else if (accept) begin
            st   <= ST_POST;
            pend <= 1'b0;
            post <= CNT_W'(DEPTH) - pre_w;
         end else if (st == ST_ARMED && trig) begin
            pend <= 1'b1;
         end else if (st == ST_POST && wr) begin
            post <= post - 1'b1;
            if (post == CNT_W'(1)) begin
               st   <= ST_STOPPED;
               rptr <= wptr + 1'b1;
            end
         end

         if (rd_go) rptr <= rptr + 1'b1;
      end
   end
endmodule

// File: rtl/cap_engine_chk.sv
module cap_engine_chk (
   input logic       clk,
   input logic       rst,
   input logic       start,
   input logic       rearm,
   input logic       next_req,
   input logic [1:0] status,
   input logic       rd_valid
);
   assert_start_R2: assert property (@(posedge clk) disable iff (rst)
      (status == 2'b00 && start && !rearm) |=> status == 2'b01);

   assert_rearm_R5: assert property (@(posedge clk) disable iff (rst)
      rearm |=> status == 2'b10);

   assert_post_entry_R6: assert property (@(posedge clk) disable iff (rst)
      (status != 2'b11) |=> (status != 2'b11 || $past(status) == 2'b10));

   assert_stay_stopped_R8: assert property (@(posedge clk) disable iff (rst)
      (status == 2'b00 && !start && !rearm) |=> status == 2'b00);

   assert_free_holds_R9: assert property (@(posedge clk) disable iff (rst)
      (status == 2'b01 && !rearm) |=> status == 2'b01);

   assert_post_exit_R9: assert property (@(posedge clk) disable iff (rst)
      (status == 2'b11 && !rearm) |=> (status == 2'b11 || status == 2'b00));

   assert_read_src_R10: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> ($past(status) == 2'b00 && $past(next_req)));

   assert_no_read_R11: assert property (@(posedge clk) disable iff (rst)
      (status != 2'b00) |=> !rd_valid);
endmodule

bind cap_engine cap_engine_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .rearm    (rearm),
   .next_req (next_req),
   .status   (status),
   .rd_valid (rd_valid)
);

// File: tb/cap_engine_bench.sv
module cap_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SW    = 2;
   localparam int DEPTH = 32;
   localparam int DW    = 5;
   localparam int PER   = 8 / SW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] decim_n = '0;
   logic [1:0]    pos_code = '0;
   logic [SW-1:0] smp_in = '0;
   logic          smp_en = 1'b0, trig = 1'b0, rearm = 1'b0, start = 1'b0, next_req = 1'b0;
   logic [7:0]    rd_data;
   logic          rd_valid;
   logic [1:0]    status;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int sv     = 0;
   bit done   = 0;
   string cur_tag = "R1";

   cap_engine #(.SAMPLE_W(SW), .DEPTH(DEPTH), .DEC_W(DW)) u_cap_engine (
      .clk(clk), .rst(rst), .decim_n(decim_n), .pos_code(pos_code),
      .smp_in(smp_in), .smp_en(smp_en), .trig(trig), .rearm(rearm),
      .start(start), .next_req(next_req), .rd_data(rd_data),
      .rd_valid(rd_valid), .status(status)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- behavioural reference ----------------
   int     m_st, m_pend, m_hist, m_post, m_wptr, m_rptr, m_rd, m_rv;
   longint m_dcnt;
   int     m_mem [DEPTH];
   int     q [$];

   function automatic int share(input logic [1:0] c);
      case (c)
         2'b00: return 0;
         2'b01: return 10;
         2'b10: return 50;
         default: return 90;
      endcase
   endfunction

   always @(posedge clk or posedge rst) begin : mdl
      int  pre, bv, old_w;
      bit  act, rs, wr, acc, rd;
      if (rst) begin
         m_st = 0; m_pend = 0; m_hist = 0; m_post = 0; m_wptr = 0; m_rptr = 0;
         m_rd = 0; m_rv = 0; m_dcnt = 0; q.delete();
         foreach (m_mem[i]) m_mem[i] = 0;
      end else begin
         act = (m_st != 0);
         rs  = (m_st == 0) && (start || rearm);
         wr  = 0; bv = 0;
         if (act && smp_en) begin
            if (m_dcnt == (longint'(1) << decim_n) - 1) begin
               m_dcnt = 0;
               q.push_back(int'(smp_in));
            end else m_dcnt++;
         end
         if (q.size() == PER) begin
            foreach (q[i]) bv = bv | (q[i] << (i * SW));
            q.delete();
            wr = 1;
         end
         if (rs) begin q.delete(); m_dcnt = 0; end
         pre = (DEPTH * share(pos_code)) / 100;
         acc = (m_st == 2) && !rearm && (trig || m_pend != 0) && (m_hist >= pre);
         rd  = (m_st == 0) && next_req && !start && !rearm;
         if (rd) begin
            m_rd = m_mem[m_rptr]; m_rv = 1; m_rptr = (m_rptr + 1) % DEPTH;
         end else m_rv = 0;
         old_w = m_wptr;
         if (wr) m_mem[old_w] = bv;
         if (rearm) begin m_st = 2; m_pend = 0; end
         else if (m_st == 0 && start) m_st = 1;
         else if (acc) begin m_st = 3; m_pend = 0; m_post = DEPTH - pre; end
         else if (m_st == 2 && trig) m_pend = 1;
         else if (m_st == 3 && wr) begin
            m_post--;
            if (m_post == 0) begin m_st = 0; m_rptr = (old_w + 1) % DEPTH; end
         end
         if (rs) begin m_hist = 0; m_wptr = 0; end
         else if (wr) begin
            m_wptr = (m_wptr + 1) % DEPTH;
            if (m_hist < DEPTH) m_hist++;
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (!rst && !done) begin
         checks++;
         if (int'(status) != m_st) begin
            fails++;
            $display("FAIL %s status act=%0d exp=%0d t=%0t", cur_tag, status, m_st, $time);
         end
         checks++;
         if (int'(rd_valid) != m_rv) begin
            fails++;
            $display("FAIL %s rd_valid act=%0d exp=%0d t=%0t", cur_tag, rd_valid, m_rv, $time);
         end
         if (m_rv != 0) begin
            checks++;
            if (int'(rd_data) != m_rd) begin
               fails++;
               $display("FAIL %s rd_data act=%0h exp=%0h t=%0t", cur_tag, rd_data, m_rd, $time);
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
         finish_run();
      end
   end

   task automatic p_start;  @(negedge clk); start = 1;    @(negedge clk); start = 0;    endtask
   task automatic p_rearm;  @(negedge clk); rearm = 1;    @(negedge clk); rearm = 0;    endtask
   task automatic p_trig;   @(negedge clk); trig = 1;     @(negedge clk); trig = 0;     endtask
   task automatic p_next;   @(negedge clk); next_req = 1; @(negedge clk); next_req = 0; endtask

   task automatic feed(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); smp_en = 1; smp_in = SW'(sv); sv = sv * 5 + 3;
      end
      @(negedge clk); smp_en = 0;
   endtask

   task automatic feed_until_stop(input int maxc);
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (status == 2'b00) break;
         smp_en = (i % 3 != 0); smp_in = SW'(sv); sv = sv * 7 + 1;
      end
      smp_en = 0;
   endtask

   task automatic read_n(input int n);
      for (int i = 0; i < n; i++) p_next();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk(status == 2'b00, "R1 status", status, 0);
      chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
      chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);

      cur_tag = "R2";
      p_start;  chk(status == 2'b01, "R2 start from stopped", status, 1);
      p_start;  chk(status == 2'b01, "R2 start ignored", status, 1);
      cur_tag = "R9";
      p_trig;   chk(status == 2'b01, "R9 trig in free run", status, 1);
      cur_tag = "R11";
      p_next;   chk(rd_valid == 1'b0, "R11 next outside stop", rd_valid, 0);

      // 10% share, no decimation: early trigger held (R7), then post fill (R8)
      cur_tag = "R7";
      pos_code = 2'b01; decim_n = 0;
      p_rearm;  chk(status == 2'b10, "R5 rearm from free run", status, 2);
      p_trig;   chk(status == 2'b10, "R7 early trig held", status, 2);
      feed(8);  chk(status == 2'b10, "R7 history short", status, 2);
      feed(4);  chk(status == 2'b10, "R7 history just filled", status, 2);
      @(negedge clk); chk(status == 2'b11, "R7 held trig released", status, 3);
      cur_tag = "R8";
      feed(115); chk(status == 2'b11, "R8 one byte short", status, 3);
      p_trig;    chk(status == 2'b11, "R9 trig in post", status, 3);
      feed(1);   chk(status == 2'b00, "R8 stop after post fill", status, 0);
      feed(20);  chk(status == 2'b00, "R8 input ignored", status, 0);
      cur_tag = "R4";
      read_n(DEPTH);
      cur_tag = "R10";
      read_n(2);
      p_trig;   chk(status == 2'b00, "R9 trig while stopped", status, 0);

      // 50% share, decimation by 4, gappy enable (R3)
      cur_tag = "R3";
      pos_code = 2'b10; decim_n = 2;
      p_rearm;  chk(status == 2'b10, "R5 rearm from stopped", status, 2);
      p_trig;
      feed_until_stop(5000);
      chk(status == 2'b00, "R3 decimated capture stopped", status, 0);
      read_n(DEPTH + 1);

      // 90% share with full history, trigger takes at once (R6)
      cur_tag = "R6";
      pos_code = 2'b11; decim_n = 0;
      @(negedge clk); start = 1; rearm = 1; @(negedge clk); start = 0; rearm = 0;
      chk(status == 2'b10, "R5 rearm beats start", status, 2);
      p_rearm;
      feed(200);
      p_trig;   chk(status == 2'b11, "R6 trig with history", status, 3);
      p_rearm;  chk(status == 2'b10, "R5 rearm in post", status, 2);
      p_trig;   chk(status == 2'b11, "R6 retrigger", status, 3);
      feed_until_stop(2000);
      chk(status == 2'b00, "R6 capture stopped", status, 0);
      read_n(DEPTH);

      // 0% share: trigger right after rearm
      cur_tag = "R6";
      pos_code = 2'b00; decim_n = 1;
      p_rearm;
      p_trig;   chk(status == 2'b11, "R6 zero share immediate", status, 3);
      p_next;   chk(rd_valid == 1'b0, "R11 next in post", rd_valid, 0);
      feed_until_stop(5000);
      chk(status == 2'b00, "R8 zero share stopped", status, 0);
      cur_tag = "R10";
      read_n(DEPTH + 3);

      finish_run();
   end
endmodule